// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block is the configuration front end of a programmable interrupt controller. Software writes 8-bit words to a two-address port with a one-bit address (even/odd). An even-address word with bit 4 set opens a setup sequence. The odd-address words that follow fill in the following settings, in this order:

- the vector base;
- optionally a cascade-topology word;
- optionally a mode word.

The block holds the resulting configuration and presents it as steady outputs to the priority core that sits beside it.

Once the last expected word has arrived, the block raises a ready flag. From then on, every odd-address write is taken as a new interrupt mask. Two flags in the opening word decide whether the cascade word and the mode word are expected. A fresh opening word restarts the sequence at any time, including partway through a sequence.

A typical master setup writes 0x11, 0x20, 0x04, 0x01. A typical slave setup writes 0x11, 0x28, 0x02, 0x01. The two setups place the eight inputs at vectors 0x20–0x27 and 0x28–0x2F.

Top module: `pic_init_seq`

## Requirements
- R1: After reset, `init_done_o` is 0, `mask_o` is 0x00 and every configuration output is 0.
- R2: An even-address write with bit 4 set restarts the sequence. In the following cycle, `init_done_o` is 0 and `mask_o` is 0x00, and `init_start_o` pulses high for exactly one cycle so the core can drop its special-mask mode.
- R3: The opening word sets the input trigger mode and the vector interval:
  - bit 3 set selects level-triggered inputs (`level_trig_o`=1); clear selects edge-triggered inputs;
  - bit 2 set selects a 4-byte vector interval (`intv4_o`=1); clear selects 8 bytes;
  - bit 1 set selects single-controller operation (`single_o`=1);
  - bit 0 set means a mode word follows.
- R4: The first odd-address write after the opening word stores its bits 7..3 on `vec_base_o`.
- R5: When `single_o` is 0, the second odd-address write is the cascade word and is stored on `casc_o`, with bits 2..0 also on `slave_id_o`. When `single_o` is 1, no cascade word is taken.
- R6: The mode word sets the following fields:
  - bit 0 drives `cpu_mode_o`;
  - bit 1 drives `auto_eoi_o`;
  - bit 3 drives `buffered_o`;
  - bit 4 drives `sfnm_o`.
  If the opening word had bit 0 clear, all of these outputs stay 0.
- R7: `is_master_o` follows `sp_role_i` when `buffered_o` is 0, and follows mode-word bit 2 when `buffered_o` is 1.
- R8: `init_done_o` rises in the cycle after the last expected word. Once it is high, each odd-address write loads `mask_o`.
- R9: While `init_done_o` is 0, an odd-address write outside a sequence leaves `mask_o` unchanged. An even-address write with bit 4 clear never changes the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one cycle per word |
| addr_i | input | 1 | 0 = even address, 1 = odd address |
| wdata_i | input | 8 | Write data |
| sp_role_i | input | 1 | Role pin used when buffering is off: 1 = master |
| init_done_o | output | 1 | Setup sequence complete |
| init_start_o | output | 1 | One-cycle pulse after an opening word |
| level_trig_o | output | 1 | Level-triggered inputs |
| intv4_o | output | 1 | 4-byte vector interval |
| single_o | output | 1 | Single-controller operation |
| vec_base_o | output | 5 | Vector base, bits 7..3 |
| casc_o | output | 8 | Stored cascade word |
| slave_id_o | output | 3 | Master input number for a slave |
| cpu_mode_o | output | 1 | Vectored processor mode |
| auto_eoi_o | output | 1 | Automatic end of interrupt |
| buffered_o | output | 1 | Buffered mode |
| is_master_o | output | 1 | Resolved master role |
| sfnm_o | output | 1 | Special fully nested mode |
| mask_o | output | 8 | Interrupt mask register |

## Verification
The assertions assume the following about the inputs:
- `wr_en_i` is a single-cycle strobe;
- `addr_i` and `wdata_i` are known whenever `wr_en_i` is high;
- no write is in flight while reset is applied.

The bench drives each write for exactly one clock between falling edges and holds the data at zero otherwise. It releases reset before any write.

// File: rtl/pic_init_pkg.sv
`timescale 1ns/1ps
package pic_init_pkg;
  localparam int DW = 8;
  localparam int BASE_W = 5;
  localparam int ID_W = 3;
  // opening-word bit positions
  localparam int W1_MARK = 4;
  localparam int W1_LVL  = 3;
  localparam int W1_INTV = 2;
  localparam int W1_SNGL = 1;
  localparam int W1_MODE = 0;
  // mode-word bit positions
  localparam int MW_CPU  = 0;
  localparam int MW_AEOI = 1;
  localparam int MW_MS   = 2;
  localparam int MW_BUF  = 3;
  localparam int MW_SFNM = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BASE, ST_CASC, ST_MODE, ST_READY
  } seq_state_e;
endpackage

// File: rtl/pic_seq_fsm.sv
`timescale 1ns/1ps
module pic_seq_fsm
  import pic_init_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic odd_wr_i,
  input  logic single_i,
  input  logic need_mode_i,
  output logic take_base_o,
  output logic take_casc_o,
  output logic take_mode_o,
  output logic take_mask_o,
  output logic done_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (start_i) state_d = ST_BASE;
    else if (odd_wr_i) begin
      unique case (state_q)
        ST_BASE: state_d = !single_i ? ST_CASC : (need_mode_i ? ST_MODE : ST_READY);
        ST_CASC: state_d = need_mode_i ? ST_MODE : ST_READY;
        ST_MODE: state_d = ST_READY;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  assign take_base_o = odd_wr_i && !start_i && state_q == ST_BASE;
  assign take_casc_o = odd_wr_i && !start_i && state_q == ST_CASC;
  assign take_mode_o = odd_wr_i && !start_i && state_q == ST_MODE;
  assign take_mask_o = odd_wr_i && !start_i && state_q == ST_READY;
  assign done_o      = state_q == ST_READY;

  // R5: a cascade word is never taken in single-controller operation
  p_no_casc_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_casc_o |-> !single_i);
  // R8: the sequence only completes on an odd write
  p_done_on_odd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(odd_wr_i));
endmodule

// File: rtl/pic_cfg_regs.sv
`timescale 1ns/1ps
module pic_cfg_regs
  import pic_init_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              take_base_i,
  input  logic              take_casc_i,
  input  logic              take_mode_i,
  input  logic              done_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              sp_role_i,
  output logic              level_trig_o,
  output logic              intv4_o,
  output logic              single_o,
  output logic              need_mode_o,
  output logic [BASE_W-1:0] vec_base_o,
  output logic [DW-1:0]     casc_o,
  output logic [ID_W-1:0]   slave_id_o,
  output logic              cpu_mode_o,
  output logic              auto_eoi_o,
  output logic              buffered_o,
  output logic              is_master_o,
  output logic              sfnm_o
);
  logic ms_bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_trig_o <= 1'b0;
      intv4_o      <= 1'b0;
      single_o     <= 1'b0;
      need_mode_o  <= 1'b0;
      vec_base_o   <= '0;
      casc_o       <= '0;
      cpu_mode_o   <= 1'b0;
      auto_eoi_o   <= 1'b0;
      buffered_o   <= 1'b0;
      ms_bit_q     <= 1'b0;
      sfnm_o       <= 1'b0;
    end else if (start_i) begin
      level_trig_o <= wdata_i[W1_LVL];
      intv4_o      <= wdata_i[W1_INTV];
      single_o     <= wdata_i[W1_SNGL];
      need_mode_o  <= wdata_i[W1_MODE];
      vec_base_o   <= '0;
      casc_o       <= '0;
      cpu_mode_o   <= 1'b0;
      auto_eoi_o   <= 1'b0;
      buffered_o   <= 1'b0;
      ms_bit_q     <= 1'b0;
      sfnm_o       <= 1'b0;
    end else begin
      if (take_base_i) vec_base_o <= wdata_i[DW-1:DW-BASE_W];
      if (take_casc_i) casc_o <= wdata_i;
      if (take_mode_i) begin
        cpu_mode_o <= wdata_i[MW_CPU];
        auto_eoi_o <= wdata_i[MW_AEOI];
        buffered_o <= wdata_i[MW_BUF];
        ms_bit_q   <= wdata_i[MW_MS];
        sfnm_o     <= wdata_i[MW_SFNM];
      end
    end
  end

  assign slave_id_o  = casc_o[ID_W-1:0];
  assign is_master_o = buffered_o ? ms_bit_q : sp_role_i;

  // R6: without a mode word every mode field stays clear
  p_nomode_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !need_mode_o) |-> !(cpu_mode_o || auto_eoi_o || buffered_o || sfnm_o));
  // R4: vector base only moves on an opening word or a base write
  p_base_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !take_base_i) |=> $stable(vec_base_o));
endmodule

// File: rtl/pic_mask_reg.sv
`timescale 1ns/1ps
module pic_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     q_o <= '0;
    else if (clr_i)  q_o <= '0;
    else if (load_i) q_o <= d_i;
endmodule

// File: rtl/pic_init_seq.sv
`timescale 1ns/1ps
module pic_init_seq
  import pic_init_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              sp_role_i,
  output logic              init_done_o,
  output logic              init_start_o,
  output logic              level_trig_o,
  output logic              intv4_o,
  output logic              single_o,
  output logic [BASE_W-1:0] vec_base_o,
  output logic [DW-1:0]     casc_o,
  output logic [ID_W-1:0]   slave_id_o,
  output logic              cpu_mode_o,
  output logic              auto_eoi_o,
  output logic              buffered_o,
  output logic              is_master_o,
  output logic              sfnm_o,
  output logic [DW-1:0]     mask_o
);
  logic start, odd_wr, need_mode;
  logic take_base, take_casc, take_mode, take_mask;

  assign start  = wr_en_i && !addr_i && wdata_i[W1_MARK];
  assign odd_wr = wr_en_i && addr_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) init_start_o <= 1'b0;
    else         init_start_o <= start;

  pic_seq_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i(start), .odd_wr_i(odd_wr),
    .single_i(single_o), .need_mode_i(need_mode),
    .take_base_o(take_base), .take_casc_o(take_casc),
    .take_mode_o(take_mode), .take_mask_o(take_mask),
    .done_o(init_done_o)
  );

  pic_cfg_regs u_cfg (
    .clk_i, .rst_ni,
    .start_i(start), .take_base_i(take_base), .take_casc_i(take_casc),
    .take_mode_i(take_mode), .done_i(init_done_o),
    .wdata_i, .sp_role_i,
    .level_trig_o, .intv4_o, .single_o, .need_mode_o(need_mode),
    .vec_base_o, .casc_o, .slave_id_o,
    .cpu_mode_o, .auto_eoi_o, .buffered_o, .is_master_o, .sfnm_o
  );

  pic_mask_reg #(.W(DW)) u_mask (
    .clk_i, .rst_ni,
    .clr_i(start), .load_i(take_mask), .d_i(wdata_i), .q_o(mask_o)
  );

  // R2: an opening word clears done and mask next cycle
  p_start_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i && wdata_i[W1_MARK]) |=> (!init_done_o && mask_o == '0 && init_start_o));
  // R2: start pulse is one cycle wide unless another opening word arrives
  p_start_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_start_o && !(wr_en_i && !addr_i && wdata_i[W1_MARK]) |=> !init_start_o);
  // R8/R9: mask changes only by an odd write while done, or by an opening word
  p_mask_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i && init_done_o) && !(wr_en_i && !addr_i && wdata_i[W1_MARK])
      |=> $stable(mask_o));
  // R8: once done, an odd write lands in the mask
  p_mask_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i && init_done_o) |=> mask_o == $past(wdata_i));
endmodule

// File: tb/pic_init_seq_test.sv
`timescale 1ns/1ps
module pic_init_seq_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0, addr = 1'b0, sp_role = 1'b1;
  logic [7:0] wdata = 8'h00;
  logic init_done, init_start, level_trig, intv4, single_m;
  logic [4:0] vec_base;
  logic [7:0] casc, mask;
  logic [2:0] slave_id;
  logic cpu_mode, auto_eoi, buffered, is_master, sfnm;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pic_init_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .sp_role_i(sp_role), .init_done_o(init_done), .init_start_o(init_start),
    .level_trig_o(level_trig), .intv4_o(intv4), .single_o(single_m),
    .vec_base_o(vec_base), .casc_o(casc), .slave_id_o(slave_id),
    .cpu_mode_o(cpu_mode), .auto_eoi_o(auto_eoi), .buffered_o(buffered),
    .is_master_o(is_master), .sfnm_o(sfnm), .mask_o(mask)
  );

  // {addr, data, exp_done, exp_base, exp_mask}
  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 8'h11, 1'b0, 5'h00, 8'h00},
    {1'b1, 8'h20, 1'b0, 5'h04, 8'h00},
    {1'b1, 8'h04, 1'b0, 5'h04, 8'h00},
    {1'b1, 8'h01, 1'b1, 5'h04, 8'h00},
    {1'b1, 8'hFB, 1'b1, 5'h04, 8'hFB},
    {1'b0, 8'h20, 1'b1, 5'h04, 8'hFB},
    {1'b0, 8'h11, 1'b0, 5'h00, 8'h00},
    {1'b1, 8'h28, 1'b0, 5'h05, 8'h00},
    {1'b1, 8'h02, 1'b0, 5'h05, 8'h00},
    {1'b1, 8'h01, 1'b1, 5'h05, 8'h00}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // drive one write for one clock, sample at the following falling edge
  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0; wdata = 8'h00;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", {15'b0, init_done}, 16'd0);
    chk("R1 mask", {8'b0, mask}, 16'h00);
    chk("R1 cfg", {5'b0, level_trig, intv4, single_m, vec_base, cpu_mode, auto_eoi, buffered, sfnm},
        16'd0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][22], VEC[i][21:14]);
      chk($sformatf("R8 done row %0d", i), {15'b0, init_done}, {15'b0, VEC[i][13]});
      chk($sformatf("R4 base row %0d", i), {11'b0, vec_base}, {11'b0, VEC[i][12:8]});
      chk($sformatf("R9 mask row %0d", i), {8'b0, mask}, {8'b0, VEC[i][7:0]});
    end
    // slave setup from table: cascade id 2, cpu mode
    chk("R5 slave id", {13'b0, slave_id}, 16'd2);
    chk("R6 cpu mode", {15'b0, cpu_mode}, 16'd1);
    chk("R7 role pin", {15'b0, is_master}, 16'd1);

    // R2 start pulse is one cycle
    @(negedge clk); wr_en = 1'b1; addr = 1'b0; wdata = 8'h11;
    @(negedge clk); wr_en = 1'b0; wdata = 8'h00;
    chk("R2 pulse high", {15'b0, init_start}, 16'd1);
    @(negedge clk);
    chk("R2 pulse low", {15'b0, init_start}, 16'd0);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h04);
    chk("R5 casc word", {8'b0, casc}, 16'h0004);
    wr(1'b1, 8'h0D);
    chk("R7 buffered master", {14'b0, buffered, is_master}, 16'b11);
    sp_role = 1'b1;

    // buffered slave overrides the pin
    wr(1'b0, 8'h11); wr(1'b1, 8'h28); wr(1'b1, 8'h02); wr(1'b1, 8'h09);
    chk("R7 buffered slave", {14'b0, buffered, is_master}, 16'b10);
    chk("R8 done slave", {15'b0, init_done}, 16'd1);

    // auto EOI and special fully nested
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h13);
    chk("R6 aeoi sfnm", {14'b0, auto_eoi, sfnm}, 16'b11);

    // R3/R5/R6 single, level, no mode word: done after base
    wr(1'b0, 8'h1A);
    chk("R3 level single", {13'b0, level_trig, intv4, single_m}, 16'b101);
    wr(1'b1, 8'h40);
    chk("R5 skip casc done", {15'b0, init_done}, 16'd1);
    chk("R5 casc untouched", {8'b0, casc}, 16'h00);
    chk("R6 mode zero", {12'b0, cpu_mode, auto_eoi, buffered, sfnm}, 16'd0);
    wr(1'b1, 8'h3C);
    chk("R8 mask after single", {8'b0, mask}, 16'h3C);

    // R3 4-byte interval, single, mode word expected
    wr(1'b0, 8'h17);
    chk("R3 intv4", {13'b0, level_trig, intv4, single_m}, 16'b011);
    wr(1'b1, 8'h08);
    chk("R8 waits for mode", {15'b0, init_done}, 16'd0);
    wr(1'b1, 8'h01);
    chk("R8 done after mode", {15'b0, init_done}, 16'd1);

    // R2 restart mid-sequence
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b0, 8'h11);
    chk("R2 restart base", {11'b0, vec_base}, 16'd0);
    wr(1'b1, 8'h30); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    chk("R2 restart done", {10'b0, init_done, vec_base}, {10'b0, 1'b1, 5'h06});

    // R9 odd write before any sequence is ignored
    do_reset();
    wr(1'b1, 8'h55);
    chk("R9 odd ignored", {7'b0, init_done, mask}, 16'h0000);
    wr(1'b0, 8'h0B);
    chk("R9 even no mark", {13'b0, level_trig, intv4, single_m}, 16'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule